// File: doc/BRIEF.md
# Programmable AND-Array Logic With Section Feedback

This block evaluates sum-of-products logic whose AND plane is set by software-visible configuration registers and whose OR plane is hard-wired. The outputs are split into sections. Each section owns a fixed set of product terms, and its output is the OR of those terms only. A product term can take any external input, in true or inverted form, as a literal. It can also take the output of any lower-numbered section. This lets a function that needs more products than one section holds be built by chaining sections.

Configuration is one word per product term. Each word is written through a synchronous address, data and write-enable port and can be read back at the same address. The outputs are purely combinational functions of the inputs and the stored words. The default build has four inputs, four sections and three products per section. Loaded with the right words, it produces four given four-variable functions. One of them is composed from another section's output plus two extra products.

Top module: `pal_array`

## Requirements
- R1: While `rst_n` is low, every configuration word is cleared to zero. After reset, every valid address reads back zero and every output is 0.
- R2: When `cfg_we` is high at a rising clock edge and `cfg_addr` is below N_SEC*N_PT, `cfg_wdata` is stored at that address. `cfg_rdata` shows the stored word at `cfg_addr` combinationally, so the new value is visible in the cycle after the edge.
- R3: A write to an address of N_SEC*N_PT or above changes no stored word. Reading such an address returns zero.
- R4: A product term with no literal enable set evaluates to 0 and contributes nothing to its section.
- R5: A term that enables both the true and the inverted form of the same literal evaluates to 0.
- R6: Literal i of a term word uses bit 2*i as its true-form enable and bit 2*i+1 as its inverted-form enable. Literals 0..N_IN-1 are `in_vec[0..N_IN-1]`. The term is the AND of every enabled literal form.
- R7: The word at address s*N_PT+t is term t of section s. `out_vec[s]` is the OR of that section's N_PT terms and of no other term.
- R8: Literal N_IN+j is the output of section j. Section s may use it when j < s.
- R9: In section s, enables for feedback literals N_IN+j with j >= s are ignored. The term behaves exactly as if those bits were clear.
- R10: With in_vec = {A,B,C,D} (A in bit 3), the reference word set gives the following outputs. `out_vec[0]` is true on minterms 2, 12 and 13. `out_vec[1]` is true on 7 through 15. `out_vec[2]` is true on 0, 2-8, 10, 11 and 15. `out_vec[3]` is true on 1, 2, 8, 12 and 13, and is built from section 0's output plus two products.
- R11: With `cfg_we` low, no stored word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all words |
| cfg_we | input | 1 | Write enable for the configuration port |
| cfg_addr | input | AW ($clog2(N_SEC*N_PT)) | Product-term word address, for both write and readback |
| cfg_wdata | input | 2*(N_IN+N_SEC) | Word to store |
| cfg_rdata | output | 2*(N_IN+N_SEC) | Stored word at `cfg_addr`, or zero for an invalid address |
| in_vec | input | N_IN | External logic inputs |
| out_vec | output | N_SEC | Section outputs |

## Verification
The bench builds the block with its defaults: four inputs, four sections and three terms per section. This makes twelve 16-bit words and a 4-bit address, so addresses 12 to 15 are available for testing invalid writes. With only 16 input combinations, every function loaded is checked exhaustively against truth tables written in the bench. These include single terms, contradictory terms, OR groupings, legal and ignored feedback, and the reference set. Feedback into the top section reaches a depth of two sections, which exercises the chained path.

// File: rtl/pal_pkg.sv
// Package pal_pkg: shared sizing helpers for the programmable AND-array block.
// Assumes literals are ordered external inputs first, then section outputs.
package pal_pkg;

    // Number of literals a product term can see.
    function automatic int lit_count(int n_in, int n_sec);
        return n_in + n_sec;
    endfunction

    // Configuration word address of term t in section s.
    function automatic int term_addr(int s, int t, int n_pt);
        return s * n_pt + t;
    endfunction

endpackage

// File: rtl/pal_cfg_store.sv
// Module pal_cfg_store: register file holding one configuration word per
// product term. Synchronous write, combinational readback, synchronous
// active-low clear. Assumes NW <= 2**AW; addresses at or above NW are inert.
module pal_cfg_store #(
    parameter int NW = 12,
    parameter int WW = 16,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WW-1:0]     wdata,
    output logic [WW-1:0]     rdata,
    output logic [NW*WW-1:0]  flat
);

    logic [WW-1:0] mem [NW];

    // Purpose: clear on reset, otherwise store a word at a valid address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NW; i++) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we && addr == AW'(i)) begin
                mem[i] <= wdata;
            end
        end
    end

    // Purpose: read the word at addr, zero when addr is out of range.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (addr == AW'(i)) begin
                rdata = mem[i];
            end
        end
    end

    // Flatten the words for the logic array.
    for (genvar g = 0; g < NW; g++) begin : g_flat
        assign flat[g*WW +: WW] = mem[g];
    end

endmodule

// File: rtl/pal_term.sv
// Module pal_term: one programmable product term. Each literal has a
// true-form and an inverted-form enable. Feedback literals not below
// SEC_IDX are masked off so the array stays acyclic. An all-clear word gives 0.
module pal_term #(
    parameter int N_IN    = 4,
    parameter int NL      = 8,
    parameter int SEC_IDX = 0
) (
    input  logic [NL-1:0]   lits,
    input  logic [2*NL-1:0] word,
    output logic            prod
);

    logic [NL-1:0] en_t;
    logic [NL-1:0] en_c;

    // Purpose: pick the enables of each literal, dropping forbidden feedback.
    for (genvar i = 0; i < NL; i++) begin : g_lit
        if (i < N_IN || (i - N_IN) < SEC_IDX) begin : g_use
            assign en_t[i] = word[2*i];
            assign en_c[i] = word[2*i+1];
        end else begin : g_drop
            assign en_t[i] = 1'b0;
            assign en_c[i] = 1'b0;
        end
    end

    // Purpose: AND of enabled literal forms, forced low when nothing is enabled.
    assign prod = (|(en_t | en_c)) & (&(~en_t | lits)) & (&(~en_c | ~lits));

endmodule

// File: rtl/pal_section.sv
// Module pal_section: one output section with N_PT dedicated product terms
// ORed together. Assumes fb carries section outputs, of which only those
// below SEC_IDX are honoured by the terms.
module pal_section #(
    parameter int N_IN    = 4,
    parameter int N_SEC   = 4,
    parameter int N_PT    = 3,
    parameter int SEC_IDX = 0,
    localparam int NL     = pal_pkg::lit_count(N_IN, N_SEC),
    localparam int WW     = 2 * NL
) (
    input  logic [N_IN-1:0]     in_vec,
    input  logic [N_SEC-1:0]    fb,
    input  logic [N_PT*WW-1:0]  words,
    output logic                sum
);

    logic [NL-1:0]   lits;
    logic [N_PT-1:0] prods;

    assign lits = {fb, in_vec};

    // Purpose: one term instance per owned product.
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        pal_term #(
            .N_IN   (N_IN),
            .NL     (NL),
            .SEC_IDX(SEC_IDX)
        ) u_term (
            .lits(lits),
            .word(words[t*WW +: WW]),
            .prod(prods[t])
        );
    end

    // Purpose: fixed OR of this section's own terms.
    assign sum = |prods;

endmodule

// File: rtl/pal_array.sv
// Module pal_array: top of the programmable AND-array with fixed OR
// sections and lower-to-higher section feedback. Outputs are combinational
// in in_vec and the stored words; configuration changes land on clk.
module pal_array #(
    parameter int N_IN  = 4,
    parameter int N_SEC = 4,
    parameter int N_PT  = 3,
    localparam int NL   = pal_pkg::lit_count(N_IN, N_SEC),
    localparam int WW   = 2 * NL,
    localparam int NW   = N_SEC * N_PT,
    localparam int AW   = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WW-1:0]    cfg_wdata,
    output logic [WW-1:0]    cfg_rdata,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_SEC-1:0] out_vec
);

    logic [NW*WW-1:0] cfg_flat;
    logic             sec_out [N_SEC];

    // Configuration registers.
    pal_cfg_store #(
        .NW(NW),
        .WW(WW),
        .AW(AW)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .rdata(cfg_rdata),
        .flat (cfg_flat)
    );

    // Purpose: build each section with feedback from lower sections only.
    for (genvar k = 0; k < N_SEC; k++) begin : g_sec
        logic [N_SEC-1:0] fb;
        for (genvar j = 0; j < N_SEC; j++) begin : g_fb
            if (j < k) begin : g_low
                assign fb[j] = sec_out[j];
            end else begin : g_high
                assign fb[j] = 1'b0;
            end
        end

        pal_section #(
            .N_IN   (N_IN),
            .N_SEC  (N_SEC),
            .N_PT   (N_PT),
            .SEC_IDX(k)
        ) u_sec (
            .in_vec(in_vec),
            .fb    (fb),
            .words (cfg_flat[pal_pkg::term_addr(k, 0, N_PT)*WW +: N_PT*WW]),
            .sum   (sec_out[k])
        );

        assign out_vec[k] = sec_out[k];
    end

endmodule

// File: rtl/pal_array_chk.sv
// Module pal_array_chk: property checks on the configuration port and
// the outputs of pal_array. Attached by bind; observes only.
module pal_array_chk #(
    parameter int N_IN  = 4,
    parameter int N_SEC = 4,
    parameter int N_PT  = 3,
    localparam int NL   = N_IN + N_SEC,
    localparam int WW   = 2 * NL,
    localparam int NW   = N_SEC * N_PT,
    localparam int AW   = (NW > 1) ? $clog2(NW) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [AW-1:0]    cfg_addr,
    input logic [WW-1:0]    cfg_wdata,
    input logic [WW-1:0]    cfg_rdata,
    input logic [NW*WW-1:0] cfg_flat,
    input logic [N_SEC-1:0] out_vec
);

    logic addr_ok;
    assign addr_ok = ({1'b0, cfg_addr} < (AW+1)'(NW));

    // R1: storage is empty on the first cycle out of reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_flat == '0));

    // R2: a valid write is seen at the same address in the next cycle.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && addr_ok) ##1 $stable(cfg_addr) |-> (cfg_rdata == $past(cfg_wdata)));

    // R3: an invalid address reads zero.
    a_r3_bad_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |-> (cfg_rdata == '0));

    // R11: without a write, the word at a held address does not move.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we) ##1 $stable(cfg_addr) |-> $stable(cfg_rdata));

    // R4: an all-empty configuration drives every output low.
    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat == '0) |-> (out_vec == '0));

endmodule

bind pal_array pal_array_chk #(
    .N_IN (N_IN),
    .N_SEC(N_SEC),
    .N_PT (N_PT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .cfg_flat (cfg_flat),
    .out_vec  (out_vec)
);

// File: tb/pal_array_test.sv
// Directed bench for pal_array with default parameters (4 in, 4 sections, 3 terms).
module pal_array_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  in_vec = '0;
    logic [3:0]  out_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam int LA = 3, LB = 2, LC = 1, LD = 0, LW = 4;

    pal_array uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_vec(in_vec), .out_vec(out_vec)
    );

    always #4 clk = ~clk;

    // Literal enable bit: bit 2*idx true form, bit 2*idx+1 inverted form.
    function automatic logic [15:0] lit(int idx, bit inv);
        return 16'(1) << (2 * idx + int'(inv));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 12; i++) wr(4'(i), 16'h0);
    endtask

    // Compare all four outputs over all 16 inputs against truth masks.
    task automatic sweep(string req, logic [15:0] m0, logic [15:0] m1,
                         logic [15:0] m2, logic [15:0] m3);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            in_vec = 4'(v);
            #1;
            chk(req, {in_vec, out_vec}, {4'(v), m3[v], m2[v], m1[v], m0[v]});
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 12; i++) rd_chk("R1 reset word", 4'(i), 16'h0);
        sweep("R1 R4 reset outputs", 16'h0, 16'h0, 16'h0, 16'h0);
    endtask

    task automatic t_write_read();
        wr(4'd0, 16'hA5C3);
        wr(4'd11, 16'h1234);
        rd_chk("R2 addr0", 4'd0, 16'hA5C3);
        rd_chk("R2 addr11", 4'd11, 16'h1234);
        @(negedge clk);
        cfg_addr = 4'd0; cfg_wdata = 16'hFFFF; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk("R11 no write", 4'd0, 16'hA5C3);
        clear_all();
    endtask

    task automatic t_bad_addr();
        wr(4'd5, 16'h00F0);
        for (int a = 12; a < 16; a++) wr(4'(a), 16'hBEEF);
        for (int i = 0; i < 12; i++)
            rd_chk("R3 valid words kept", 4'(i), (i == 5) ? 16'h00F0 : 16'h0);
        rd_chk("R3 invalid reads zero", 4'd12, 16'h0);
        rd_chk("R3 invalid reads zero", 4'd15, 16'h0);
        clear_all();
    endtask

    task automatic t_literal();
        // Section 0 term 0 = A & ~D : minterms 8,10,12,14.
        wr(4'd0, lit(LA, 0) | lit(LD, 1));
        sweep("R6 literal AND", 16'h5500, 16'h0, 16'h0, 16'h0);
        // Add true D too: contradictory term.
        wr(4'd0, lit(LA, 0) | lit(LD, 1) | lit(LD, 0));
        sweep("R5 contradiction", 16'h0, 16'h0, 16'h0, 16'h0);
        wr(4'd0, 16'h0);
        sweep("R4 empty term", 16'h0, 16'h0, 16'h0, 16'h0);
    endtask

    task automatic t_or();
        // Section 1 term 0 = A, term 2 = B ; term 1 empty.
        wr(4'd3, lit(LA, 0));
        wr(4'd5, lit(LB, 0));
        sweep("R7 section OR", 16'h0, 16'hFFF0, 16'h0, 16'h0);
        clear_all();
    endtask

    task automatic t_feedback();
        // Section 0: A | (B with ignored self-feedback enable).
        wr(4'd0, lit(LA, 0));
        wr(4'd1, lit(LB, 0) | lit(LW, 1));
        // Section 1: C with ignored feedback of section 3.
        wr(4'd3, lit(LC, 0) | lit(LW + 3, 0));
        // Section 2: section 0 output & D.
        wr(4'd6, lit(LW, 0) | lit(LD, 0));
        // Section 3: section 2 output inverted & C.
        wr(4'd9, lit(LW + 2, 1) | lit(LC, 0));
        // s0 = A|B = FFF0; s1 = C = CCCC; s2 = (A|B)&D = AAA0; s3 = C & ~s2 = 444C.
        sweep("R8 R9 feedback", 16'hFFF0, 16'hCCCC, 16'hAAA0, 16'h444C);
        clear_all();
    endtask

    task automatic t_reference();
        wr(4'd0,  lit(LA, 0) | lit(LB, 0) | lit(LC, 1));
        wr(4'd1,  lit(LA, 1) | lit(LB, 1) | lit(LC, 0) | lit(LD, 1));
        wr(4'd3,  lit(LA, 0));
        wr(4'd4,  lit(LB, 0) | lit(LC, 0) | lit(LD, 0));
        wr(4'd6,  lit(LA, 1) | lit(LB, 0));
        wr(4'd7,  lit(LC, 0) | lit(LD, 0));
        wr(4'd8,  lit(LB, 1) | lit(LD, 1));
        wr(4'd9,  lit(LW, 0));
        wr(4'd10, lit(LA, 1) | lit(LB, 1) | lit(LC, 1) | lit(LD, 0));
        wr(4'd11, lit(LA, 0) | lit(LC, 1) | lit(LD, 1));
        sweep("R10 reference", 16'h3004, 16'hFF80, 16'h8DFD, 16'h3106);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_bad_addr();
        t_literal();
        t_or();
        t_feedback();
        t_reference();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule